// File: doc/BRIEF.md
# Runahead Checkpoint Register File

This block is an integer register file for a core that keeps executing past a long cache miss to warm caches. It holds two copies of every register, a primary bank and a backup bank, and a per-register invalid flag. Outside speculation each write lands in both banks, so the backup always mirrors the primary. When speculation starts, reads and writes move to the backup bank alone. The primary bank then holds the checkpoint, and taking it costs no copy cycle.

During speculation every write carries a poison flag. The flag is set when any source operand of the producing instruction was poisoned, or when the instruction was a load that missed in the cache. Each read port returns that flag beside the data. When speculation ends, all flags clear and architectural reads return to the primary bank. A resync sequencer then copies the primary back into the backup, one register per cycle, unless the one-cycle parallel copy is selected.

Three named states drive the block. IDLE_ARCH (mode 0) is normal operation. SPEC (mode 1) is runahead. RESYNC (mode 2) is the copy-back. The transitions are:
- `go_spec`: IDLE_ARCH to SPEC when `enter_i` is high.
- `leave_spec`: SPEC to RESYNC when `exit_i` is high.
- `copy_done`: RESYNC to IDLE_ARCH once the last register has been copied.

Top module: `ckpt_regfile`

## Requirements
- R1: After reset, `mode_o` is 0 and every register reads as zero with its invalid flag low on both ports.
- R2: In modes 0 and 2, a write to a nonzero register updates the primary bank and the backup bank together. The value is visible through the primary at once and through the backup after entering mode 1.
- R3: In modes 0 and 2, reads come from the primary bank and the invalid flag is always low.
- R4: In mode 1, writes never change the primary bank. After leaving mode 1, reads return the values that the registers held on entry, plus any later non-speculative writes.
- R5: In mode 1, reads come from the backup bank and return the stored invalid flag.
- R6: In mode 1, a write stores an invalid flag equal to `src_inv_i OR ld_miss_i`. A later write with both inputs low clears the flag.
- R7: Register 0 always reads zero with a low invalid flag, and writes to it have no effect.
- R8: A read of the register being written in the same cycle returns `wdata_i`. Its invalid flag is `src_inv_i OR ld_miss_i` in mode 1 and low otherwise.
- R9: `exit_i` in mode 1 moves to mode 2 on the next edge and clears all invalid flags. With the sequential copy, mode 2 lasts NREG-1 cycles plus one cycle for each cycle that carries a write to a nonzero register. With the parallel copy it lasts one cycle.
- R10: After mode 2 completes, a fresh entry into mode 1 reads exactly the primary contents, including writes made during mode 2.
- R11: `enter_i` is honoured only in mode 0 and `exit_i` only in mode 1. Elsewhere they do not change `mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_i | input | 1 | Start speculation (mode 0 only) |
| exit_i | input | 1 | End speculation (mode 1 only) |
| we_i | input | 1 | Write enable |
| waddr_i | input | AW | Write register index |
| wdata_i | input | XLEN | Write data |
| src_inv_i | input | 1 | Some source of the writing instruction was poisoned |
| ld_miss_i | input | 1 | Writing instruction is a load that missed |
| ra_addr_i | input | AW | Read port A index |
| ra_data_o | output | XLEN | Read port A data |
| ra_inv_o | output | 1 | Read port A invalid flag |
| rb_addr_i | input | AW | Read port B index |
| rb_data_o | output | XLEN | Read port B data |
| rb_inv_o | output | 1 | Read port B invalid flag |
| mode_o | output | 2 | 0 normal, 1 speculative, 2 resync |

## Verification
The hardest case to reach is a stale backup that survives a resync. It only shows up if speculation has dirtied the backup, the copy-back has been interleaved with fresh architectural writes that stall the sequencer, and a second speculation then reads the backup before writing to it. The bench sweeps every register through a full dirty-speculate and exit cycle. It then runs a resync with writes injected every fourth cycle, counts the cycles spent in mode 2 against NREG-1 plus the number of writes, and re-enters speculation to sweep all registers against the arithmetic model.

// File: rtl/ckpt_rf_pkg.sv
package ckpt_rf_pkg;
    typedef enum logic [1:0] {
        RF_IDLE_ARCH = 2'd0,
        RF_SPEC      = 2'd1,
        RF_RESYNC    = 2'd2
    } rf_mode_e;
endpackage

// File: rtl/ckpt_rf_ctrl.sv
module ckpt_rf_ctrl
    import ckpt_rf_pkg::*;
#(
    parameter int NREG            = 32,
    parameter int PARALLEL_RESYNC = 0,
    localparam int AW             = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enter_i,
    input  logic          exit_i,
    input  logic          wr_busy_i,
    output rf_mode_e      mode_o,
    output logic          copy_we_o,
    output logic [AW-1:0] copy_idx_o,
    output logic          copy_all_o,
    output logic          clr_inv_o
);
    localparam logic [AW-1:0] LAST_IDX = AW'(NREG - 1);

    rf_mode_e      state_q, state_d;
    logic [AW-1:0] idx_q, idx_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RF_IDLE_ARCH;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            RF_IDLE_ARCH: begin
                if (enter_i) state_d = RF_SPEC;          // go_spec
            end
            RF_SPEC: begin
                if (exit_i) begin                         // leave_spec
                    state_d = RF_RESYNC;
                    idx_d   = AW'(1);
                end
            end
            RF_RESYNC: begin
                if (PARALLEL_RESYNC != 0) begin
                    state_d = RF_IDLE_ARCH;               // copy_done
                end else if (!wr_busy_i) begin
                    if (idx_q == LAST_IDX) state_d = RF_IDLE_ARCH;
                    else                   idx_d   = AW'(idx_q + 1'b1);
                end
            end
            default: state_d = RF_IDLE_ARCH;
        endcase
    end

    // outputs
    always_comb begin
        mode_o     = state_q;
        copy_idx_o = idx_q;
        copy_we_o  = (state_q == RF_RESYNC) && (PARALLEL_RESYNC == 0) && !wr_busy_i;
        copy_all_o = (state_q == RF_RESYNC) && (PARALLEL_RESYNC != 0);
        clr_inv_o  = (state_q == RF_SPEC) && exit_i;
    end

    p_exit_to_resync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RF_SPEC && exit_i) |=> state_q == RF_RESYNC);

    p_no_spec_from_resync_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RF_RESYNC) |=> state_q != RF_SPEC);

    p_spec_only_from_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != RF_SPEC) |=> (state_q == RF_SPEC) -> ($past(state_q) == RF_IDLE_ARCH));

    generate
        if (PARALLEL_RESYNC == 0) begin : g_seq_chk
            p_copy_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == RF_RESYNC && wr_busy_i) |=> (state_q == RF_RESYNC) && $stable(idx_q));
        end
    endgenerate
endmodule

// File: rtl/ckpt_rf_bank.sv
module ckpt_rf_bank #(
    parameter int NREG  = 32,
    parameter int XLEN  = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_i,
    input  logic [AW-1:0]               waddr_i,
    input  logic [XLEN-1:0]             wdata_i,
    input  logic                        copy_all_i,
    input  logic [NREG-1:1][XLEN-1:0]   copy_src_i,
    output logic [NREG-1:0][XLEN-1:0]   regs_o
);
    logic [XLEN-1:0] mem [1:NREG-1];

    assign regs_o[0] = '0;

    generate
        for (genvar g = 1; g < NREG; g++) begin : g_ent
            always_ff @(posedge clk) begin
                if (!rst_n)                            mem[g] <= '0;
                else if (we_i && waddr_i == AW'(g))    mem[g] <= wdata_i;
                else if (copy_all_i)                   mem[g] <= copy_src_i[g];
            end
            assign regs_o[g] = mem[g];
        end
    endgenerate
endmodule

// File: rtl/ckpt_rf_inv.sv
module ckpt_rf_inv #(
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_i,
    input  logic [AW-1:0]   idx_i,
    input  logic            val_i,
    input  logic            clr_i,
    output logic [NREG-1:0] inv_o
);
    logic [NREG-1:0] inv_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                       inv_q <= '0;
        else if (clr_i)                   inv_q <= '0;
        else if (set_i && idx_i != '0)    inv_q[idx_i] <= val_i;
    end

    assign inv_o = inv_q;

    p_inv_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> inv_q == '0);

    p_inv_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i && idx_i != '0) |=> inv_q[$past(idx_i)] == $past(val_i));
endmodule

// File: rtl/ckpt_regfile.sv
module ckpt_regfile
    import ckpt_rf_pkg::*;
#(
    parameter int NREG            = 32,
    parameter int XLEN            = 32,
    parameter int PARALLEL_RESYNC = 0,
    localparam int AW             = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter_i,
    input  logic            exit_i,
    input  logic            we_i,
    input  logic [AW-1:0]   waddr_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic            src_inv_i,
    input  logic            ld_miss_i,
    input  logic [AW-1:0]   ra_addr_i,
    output logic [XLEN-1:0] ra_data_o,
    output logic            ra_inv_o,
    input  logic [AW-1:0]   rb_addr_i,
    output logic [XLEN-1:0] rb_data_o,
    output logic            rb_inv_o,
    output logic [1:0]      mode_o
);
    rf_mode_e      mode;
    logic          copy_we, copy_all, clr_inv;
    logic [AW-1:0] copy_idx;
    logic          in_spec, wr_nz, w_inv;
    logic          prim_we, back_we;
    logic [AW-1:0]   back_waddr;
    logic [XLEN-1:0] back_wdata;
    logic [NREG-1:0][XLEN-1:0] prim_regs, back_regs;
    logic [NREG-1:0] inv_vec;

    assign in_spec = (mode == RF_SPEC);
    assign wr_nz   = we_i && (waddr_i != '0);
    assign w_inv   = src_inv_i | ld_miss_i;

    // write routing: architectural writes hit both banks, speculative only backup
    assign prim_we    = wr_nz && !in_spec;
    assign back_we    = wr_nz || copy_we;
    assign back_waddr = wr_nz ? waddr_i : copy_idx;
    assign back_wdata = wr_nz ? wdata_i : prim_regs[copy_idx];

    ckpt_rf_ctrl #(.NREG(NREG), .PARALLEL_RESYNC(PARALLEL_RESYNC)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .enter_i(enter_i), .exit_i(exit_i),
        .wr_busy_i(wr_nz), .mode_o(mode), .copy_we_o(copy_we),
        .copy_idx_o(copy_idx), .copy_all_o(copy_all), .clr_inv_o(clr_inv)
    );

    ckpt_rf_bank #(.NREG(NREG), .XLEN(XLEN)) i_prim (
        .clk(clk), .rst_n(rst_n), .we_i(prim_we), .waddr_i(waddr_i),
        .wdata_i(wdata_i), .copy_all_i(1'b0), .copy_src_i('0), .regs_o(prim_regs)
    );

    ckpt_rf_bank #(.NREG(NREG), .XLEN(XLEN)) i_back (
        .clk(clk), .rst_n(rst_n), .we_i(back_we), .waddr_i(back_waddr),
        .wdata_i(back_wdata), .copy_all_i(copy_all),
        .copy_src_i(prim_regs[NREG-1:1]), .regs_o(back_regs)
    );

    ckpt_rf_inv #(.NREG(NREG)) i_inv (
        .clk(clk), .rst_n(rst_n), .set_i(wr_nz && in_spec), .idx_i(waddr_i),
        .val_i(w_inv), .clr_i(clr_inv), .inv_o(inv_vec)
    );

    // read ports with same-cycle bypass
    logic [1:0][AW-1:0]   raddr;
    logic [1:0][XLEN-1:0] rdata;
    logic [1:0]           rinv;
    assign raddr = {rb_addr_i, ra_addr_i};

    generate
        for (genvar p = 0; p < 2; p++) begin : g_rd
            always_comb begin
                if (raddr[p] == '0) begin
                    rdata[p] = '0;
                    rinv[p]  = 1'b0;
                end else if (wr_nz && waddr_i == raddr[p]) begin
                    rdata[p] = wdata_i;
                    rinv[p]  = in_spec & w_inv;
                end else if (in_spec) begin
                    rdata[p] = back_regs[raddr[p]];
                    rinv[p]  = inv_vec[raddr[p]];
                end else begin
                    rdata[p] = prim_regs[raddr[p]];
                    rinv[p]  = 1'b0;
                end
            end
        end
    endgenerate

    assign ra_data_o = rdata[0];
    assign ra_inv_o  = rinv[0];
    assign rb_data_o = rdata[1];
    assign rb_inv_o  = rinv[1];
    assign mode_o    = mode;

    p_arch_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_spec |-> !ra_inv_o && !rb_inv_o);

    p_primary_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_spec |=> $stable(prim_regs));

    p_arch_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_nz && !in_spec) |=> prim_regs[$past(waddr_i)] == $past(wdata_i)
                                && back_regs[$past(waddr_i)] == $past(wdata_i));

    p_zero_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_addr_i == '0) |-> (ra_data_o == '0) && !ra_inv_o);
endmodule

// File: tb/test_ckpt_regfile.sv
`timescale 1ns/1ps
module test_ckpt_regfile;
    localparam int NREG = 32;
    localparam int XLEN = 32;
    localparam int AW   = 5;
    localparam int PAR  = 0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enter_i = 0, exit_i = 0, we_i = 0, src_inv_i = 0, ld_miss_i = 0;
    logic [AW-1:0] waddr_i = '0, ra_addr_i = '0, rb_addr_i = '0;
    logic [XLEN-1:0] wdata_i = '0;
    logic [XLEN-1:0] ra_data_o, rb_data_o;
    logic ra_inv_o, rb_inv_o;
    logic [1:0] mode_o;

    always #2 clk = ~clk;

    ckpt_regfile #(.NREG(NREG), .XLEN(XLEN), .PARALLEL_RESYNC(PAR)) i_ckpt_regfile (
        .clk(clk), .rst_n(rst_n), .enter_i(enter_i), .exit_i(exit_i), .we_i(we_i),
        .waddr_i(waddr_i), .wdata_i(wdata_i), .src_inv_i(src_inv_i), .ld_miss_i(ld_miss_i),
        .ra_addr_i(ra_addr_i), .ra_data_o(ra_data_o), .ra_inv_o(ra_inv_o),
        .rb_addr_i(rb_addr_i), .rb_data_o(rb_data_o), .rb_inv_o(rb_inv_o), .mode_o(mode_o)
    );

    int nchk = 0, nerr = 0;
    logic [XLEN-1:0] pm [NREG];
    logic [XLEN-1:0] bm [NREG];
    logic            im [NREG];
    int mode_m = 0;

    function automatic logic [XLEN-1:0] fval(input int i);
        return 32'hA500_0000 ^ (i * 32'h0101_0101);
    endfunction
    function automatic logic [XLEN-1:0] gval(input int i);
        return ~fval(i) + i;
    endfunction

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        enter_i = 0; exit_i = 0; we_i = 0; src_inv_i = 0; ld_miss_i = 0;
    endtask

    // expected read of register a under the model, no write in flight
    task automatic exp_rd(input int a, output logic [XLEN-1:0] d, output logic v);
        if (a == 0)          begin d = '0;    v = 1'b0;  end
        else if (mode_m == 1) begin d = bm[a]; v = im[a]; end
        else                 begin d = pm[a]; v = 1'b0;  end
    endtask

    // one cycle: read a on port A and a+7 on port B, check, advance
    task automatic rd_cycle(input int a, input string tag);
        logic [XLEN-1:0] d; logic v;
        int b;
        b = (a + 7) % NREG;
        ra_addr_i = AW'(a); rb_addr_i = AW'(b);
        #1;
        exp_rd(a, d, v);
        chk({tag, " portA data"}, ra_data_o, d);
        chk({tag, " portA inv"}, {31'b0, ra_inv_o}, {31'b0, v});
        exp_rd(b, d, v);
        chk({tag, " portB data"}, rb_data_o, d);
        chk({tag, " portB inv"}, {31'b0, rb_inv_o}, {31'b0, v});
        tick();
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < NREG; a++) rd_cycle(a, tag);
    endtask

    // run resync to completion; inject writes every 4th cycle if wr set
    task automatic run_resync(input bit wr, input bit poke_enter, input string tag);
        int cnt = 0, k = 0, exp_len;
        while (mode_o == 2'd2 && cnt < 300) begin
            quiet();
            ra_addr_i = AW'(cnt % NREG);
            if (poke_enter && cnt == 5) enter_i = 1;
            if (wr && (cnt % 4 == 1)) begin
                int w;
                w = (cnt * 7) % (NREG - 1) + 1;
                we_i = 1; waddr_i = AW'(w); wdata_i = 32'h5A00_0000 + cnt;
            end
            #1;
            if (!we_i || waddr_i != ra_addr_i) begin
                logic [XLEN-1:0] d; logic v;
                exp_rd(cnt % NREG, d, v);
                chk({tag, " R4 resync read primary"}, ra_data_o, d);
                chk({tag, " R3 resync inv low"}, {31'b0, ra_inv_o}, 32'd0);
            end
            tick();
            if (we_i) begin
                pm[waddr_i] = wdata_i; bm[waddr_i] = wdata_i; k++;
            end
            cnt++;
        end
        quiet();
        exp_len = (PAR != 0) ? 1 : (NREG - 1 + k);
        chk({tag, " R9 resync length"}, cnt, exp_len);
        chk({tag, " R11 mode after resync"}, {30'b0, mode_o}, 32'd0);
        mode_m = 0;
        for (int i = 0; i < NREG; i++) bm[i] = pm[i];
    endtask

    initial begin
        #(200000 * 4);
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin pm[i] = '0; bm[i] = '0; im[i] = 1'b0; end
        @(negedge clk); tick(); rst_n = 1;
        // R1 reset state
        chk("R1 mode after reset", {30'b0, mode_o}, 32'd0);
        sweep("R1 reset");

        // R2 R8 R7: architectural writes with bypass check
        for (int i = 0; i < NREG; i++) begin
            we_i = 1; waddr_i = AW'(i); wdata_i = fval(i); ra_addr_i = AW'(i);
            #1;
            chk("R8 arch bypass data", ra_data_o, (i == 0) ? '0 : fval(i));
            chk("R8 arch bypass inv", {31'b0, ra_inv_o}, 32'd0);
            tick();
            if (i != 0) begin pm[i] = fval(i); bm[i] = fval(i); end
        end
        quiet();
        sweep("R2 R3 R7 arch");

        // R11 exit ignored in mode 0
        exit_i = 1; tick(); quiet();
        chk("R11 exit in mode 0", {30'b0, mode_o}, 32'd0);

        // enter speculation
        enter_i = 1; tick(); quiet(); mode_m = 1;
        chk("R11 enter honoured", {30'b0, mode_o}, 32'd1);
        sweep("R2 R5 backup mirror");

        // R6 R8 speculative writes with poison pattern
        for (int i = 0; i < NREG; i++) begin
            logic pv;
            pv = (i % 3 == 0) || (i % 5 == 0);
            we_i = 1; waddr_i = AW'(i); wdata_i = gval(i);
            src_inv_i = (i % 3 == 0); ld_miss_i = (i % 5 == 0);
            enter_i = (i == 10); exit_i = 0;
            ra_addr_i = AW'(i);
            #1;
            chk("R8 spec bypass data", ra_data_o, (i == 0) ? '0 : gval(i));
            chk("R8 R6 spec bypass inv", {31'b0, ra_inv_o}, {31'b0, (i != 0) && pv});
            tick();
            if (i != 0) begin bm[i] = gval(i); im[i] = pv; end
        end
        quiet();
        chk("R11 enter in mode 1", {30'b0, mode_o}, 32'd1);
        sweep("R5 R6 R7 spec");

        // R6 clean rewrite clears poison on register 15
        we_i = 1; waddr_i = AW'(15); wdata_i = 32'h0000_F00D; tick(); quiet();
        bm[15] = 32'h0000_F00D; im[15] = 1'b0;
        rd_cycle(15, "R6 clean rewrite");

        // leave speculation
        exit_i = 1; tick(); quiet(); mode_m = 2;
        for (int i = 0; i < NREG; i++) im[i] = 1'b0;
        chk("R9 mode after exit", {30'b0, mode_o}, (PAR != 0) ? 32'd2 : 32'd2);
        run_resync(1'b0, 1'b1, "pass1");
        sweep("R4 primary restored");

        // R10 backup resynchronised, R9 flags cleared
        enter_i = 1; tick(); quiet(); mode_m = 1;
        sweep("R10 R9 after resync");

        // dirty the backup again, then resync with interleaved writes
        for (int i = 1; i < NREG; i += 2) begin
            we_i = 1; waddr_i = AW'(i); wdata_i = ~gval(i); ld_miss_i = 1;
            tick();
            bm[i] = ~gval(i); im[i] = 1'b1;
        end
        quiet();
        exit_i = 1; tick(); quiet(); mode_m = 2;
        for (int i = 0; i < NREG; i++) im[i] = 1'b0;
        run_resync(1'b1, 1'b0, "pass2");

        enter_i = 1; tick(); quiet(); mode_m = 1;
        sweep("R10 after stalled resync");
        exit_i = 1; tick(); quiet(); mode_m = 2;
        run_resync(1'b0, 1'b0, "pass3");

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule